// File: doc/BRIEF.md
# Serial-Loaded Bank Switching Controller

This block sits in a cartridge-side memory mapper and turns CPU stores into bank selections. The CPU cannot write a full register at once. It stores into the upper half of its address space, and each store gives one bit, taken from data bit 0, to a five-bit accumulator. The fifth accepted bit completes a value. That value goes to one of four internal registers, chosen by address bits 14:13 of that fifth store. A store with data bit 7 set is an escape: it drops any partly loaded value and forces the program-mode field of the control register to its fixed-high setting.

Four outputs are derived from a snapshot of the registers: a low and a high 16 KB program bank number, and a low and a high 4 KB character bank number. The snapshot is taken only when a value is committed. The control register also drives the two-bit nametable mirroring mode. The total number of program banks is an input, and the fixed-high program slot uses it to name the last bank. Turning bank numbers into ROM addresses is done outside this block.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset, the control register holds 0x0C and the other three registers hold zero. With those values the outputs are: low program bank 0, high program bank equal to the bank count minus one, character banks 0 and 1, and mirroring 0.
- R2: A store whose address bit 15 is 0 has no effect, whatever its data bit 7. The outputs do not change, and the bit count of a partly loaded value does not advance.
- R3: A store to the upper half with data bit 7 set discards the bits already collected. The next five ordinary stores then form a new value.
- R4: The escape store forces control bits 3:2 to 11 and leaves control bits 4 and 1:0 unchanged. Bank outputs take the forced mode only at the next commit.
- R5: Bits are collected least significant first. Each ordinary store shifts the accumulator right and puts data bit 0 into accumulator bit 4. Data bits 6:1 are ignored.
- R6: Address bits 14:13 of the fifth store pick the destination: 00 control, 01 character register A, 10 character register B, 11 program register. The addresses of the first four stores do not matter.
- R7: The mirroring output equals control bits 1:0.
- R8: When control bit 4 is 0, the character outputs are register A with bit 0 cleared (low) and register A with bit 0 set (high). When control bit 4 is 1, the low output is register A and the high output is register B.
- R9: When control bits 3:2 are 00 or 01, the program outputs are the program register with bit 0 cleared (low) and with bit 0 set (high).
- R10: When control bits 3:2 are 10, the low program output is 0 and the high program output is the program register.
- R11: When control bits 3:2 are 11, the low program output is the program register and the high program output is the bank count minus one. The high output follows changes of the count input without any store.
- R12: Bank outputs change only on the clock edge that samples a fifth bit. They are visible in the cycle after that edge and hold at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address of the store |
| cpu_data | input | 8 | CPU store data |
| cpu_we | input | 1 | Store strobe, sampled once per clock |
| prg_bank_count | input | 6 | Number of 16 KB program banks present |
| prg_lo_bank | output | 5 | 16 KB bank for the low program slot |
| prg_hi_bank | output | 5 | 16 KB bank for the high program slot |
| chr_lo_bank | output | 5 | 4 KB bank for the low character slot |
| chr_hi_bank | output | 5 | 4 KB bank for the high character slot |
| mirror_mode | output | 2 | Nametable mirroring mode |

## Verification
The hardest case to reach is the gap between an escape store and the next commit. In that window the control register already holds the forced program mode, but the bank outputs must still show the old snapshot. Directed sequences first set program mode 2 and send an escape. They then check that the outputs are unchanged, and only after that commit a character register and expect the fixed-high mapping to appear. Random sequences mix in lower-half stores and escapes in the middle of a load, so that partial loads are often cut short. A model in the bench tracks the bit count across those interruptions.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    localparam int REG_W        = 5;
    localparam int SEL_W        = 2;
    localparam int CHR_MODE_BIT = 4;
    localparam int PRG_MODE_HI  = 3;
    localparam int PRG_MODE_LO  = 2;
    localparam logic [REG_W-1:0] CTRL_RESET = 5'h0C;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_CHRA = 2'd1,
        SEL_CHRB = 2'd2,
        SEL_PRG  = 2'd3
    } sbc_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] chra;
        logic [REG_W-1:0] chrb;
        logic [REG_W-1:0] prg;
    } sbc_regs_t;

    typedef struct packed {
        logic [REG_W-1:0] prg_lo;
        logic [REG_W-1:0] prg_hi;
        logic [REG_W-1:0] chr_lo;
        logic [REG_W-1:0] chr_hi;
    } sbc_banks_t;
endpackage

// File: rtl/sbc_serial_loader.sv
module sbc_serial_loader
    import sbc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             commit_o,
    output logic [REG_W-1:0] commit_val_o,
    output logic [SEL_W-1:0] commit_sel_o,
    output logic             escape_o
);
    localparam int LEFT_W = $clog2(REG_W + 1);
    localparam logic [LEFT_W-1:0] LEFT_LOAD = LEFT_W'(REG_W);

    typedef struct packed {
        logic [REG_W-1:0]  acc;
        logic [LEFT_W-1:0] left;
    } ld_state_t;

    ld_state_t st_d, st_q;
    logic [REG_W-1:0] shifted;

    always_comb begin
        st_d         = st_q;
        commit_o     = 1'b0;
        escape_o     = 1'b0;
        shifted      = {data_i[0], st_q.acc[REG_W-1:1]};
        commit_val_o = shifted;
        commit_sel_o = sel_i;
        if (wr_i) begin
            if (data_i[DATA_W-1]) begin
                escape_o  = 1'b1;
                st_d.acc  = '0;
                st_d.left = LEFT_LOAD;
            end else begin
                st_d.acc = shifted;
                if (st_q.left == LEFT_W'(1)) begin
                    commit_o  = 1'b1;
                    st_d.left = LEFT_LOAD;
                end else begin
                    st_d.left = st_q.left - LEFT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc  <= '0;
            st_q.left <= LEFT_LOAD;
        end else begin
            st_q <= st_d;
        end
    end

    p_left_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.left != '0) && (st_q.left <= LEFT_LOAD));

    p_escape_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && data_i[DATA_W-1]) |=> (st_q.left == LEFT_LOAD) && (st_q.acc == '0));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(st_q));

    p_commit_reloads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> st_q.left == LEFT_LOAD);
endmodule

// File: rtl/sbc_reg_bank.sv
module sbc_reg_bank
    import sbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [REG_W-1:0] val_i,
    input  logic             escape_i,
    output sbc_regs_t        regs_q_o,
    output sbc_regs_t        regs_d_o
);
    sbc_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (escape_i) begin
            regs_d.ctrl[PRG_MODE_HI:PRG_MODE_LO] = 2'b11;
        end
        if (commit_i) begin
            case (sbc_sel_e'(sel_i))
                SEL_CTRL: regs_d.ctrl = val_i;
                SEL_CHRA: regs_d.chra = val_i;
                SEL_CHRB: regs_d.chrb = val_i;
                default:  regs_d.prg  = val_i;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctrl <= CTRL_RESET;
            regs_q.chra <= '0;
            regs_q.chrb <= '0;
            regs_q.prg  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_q_o = regs_q;
    assign regs_d_o = regs_d;

    p_escape_forces_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        escape_i |=> regs_q.ctrl[PRG_MODE_HI:PRG_MODE_LO] == 2'b11);

    p_escape_keeps_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (escape_i && !commit_i) |=> ($stable(regs_q.ctrl[1:0]) && $stable(regs_q.ctrl[CHR_MODE_BIT])
                                     && $stable(regs_q.prg)));

    p_prg_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && sel_i == SEL_PRG) |=> regs_q.prg == $past(val_i));

    p_ctrl_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!escape_i && !(commit_i && sel_i == SEL_CTRL)) |=> $stable(regs_q.ctrl));
endmodule

// File: rtl/sbc_bank_map.sv
module sbc_bank_map
    import sbc_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  sbc_regs_t        regs_nx_i,
    input  logic [CNT_W-1:0] bank_count_i,
    output sbc_banks_t       banks_o
);
    localparam int NSLOT = 2;

    sbc_regs_t snap_d, snap_q;
    logic [REG_W-1:0] last_bank;
    logic [1:0]       prg_mode;
    logic [REG_W-1:0] chr_slot [NSLOT];

    always_comb begin
        snap_d = snap_q;
        if (commit_i) begin
            snap_d = regs_nx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q.ctrl <= CTRL_RESET;
            snap_q.chra <= '0;
            snap_q.chrb <= '0;
            snap_q.prg  <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_chr_slot
        always_comb begin
            if (snap_q.ctrl[CHR_MODE_BIT]) begin
                chr_slot[i] = (i == 0) ? snap_q.chra : snap_q.chrb;
            end else begin
                chr_slot[i] = {snap_q.chra[REG_W-1:1], (i != 0)};
            end
        end
    end

    always_comb begin
        last_bank = REG_W'(bank_count_i - CNT_W'(1));
        prg_mode  = snap_q.ctrl[PRG_MODE_HI:PRG_MODE_LO];
        banks_o.chr_lo = chr_slot[0];
        banks_o.chr_hi = chr_slot[1];
        case (prg_mode)
            2'b10: begin
                banks_o.prg_lo = '0;
                banks_o.prg_hi = snap_q.prg;
            end
            2'b11: begin
                banks_o.prg_lo = snap_q.prg;
                banks_o.prg_hi = last_bank;
            end
            default: begin
                banks_o.prg_lo = {snap_q.prg[REG_W-1:1], 1'b0};
                banks_o.prg_hi = {snap_q.prg[REG_W-1:1], 1'b1};
            end
        endcase
    end

    p_snap_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(snap_q));

    p_chr_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_q.ctrl[CHR_MODE_BIT] |-> (banks_o.chr_hi == (banks_o.chr_lo | REG_W'(1)))
                                        && !banks_o.chr_lo[0]);

    p_mode2_low_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_mode == 2'b10) |-> banks_o.prg_lo == '0);

    p_pair_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !prg_mode[1] |-> (banks_o.prg_hi == (banks_o.prg_lo | REG_W'(1))));
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
    import sbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_we,
    input  logic [CNT_W-1:0]  prg_bank_count,
    output logic [REG_W-1:0]  prg_lo_bank,
    output logic [REG_W-1:0]  prg_hi_bank,
    output logic [REG_W-1:0]  chr_lo_bank,
    output logic [REG_W-1:0]  chr_hi_bank,
    output logic [1:0]        mirror_mode
);
    logic             upper_wr;
    logic [SEL_W-1:0] sel;
    logic             commit;
    logic [REG_W-1:0] commit_val;
    logic [SEL_W-1:0] commit_sel;
    logic             escape;
    sbc_regs_t        regs_q;
    sbc_regs_t        regs_nx;
    sbc_banks_t       banks;

    assign upper_wr = cpu_we & cpu_addr[ADDR_W-1];
    assign sel      = cpu_addr[ADDR_W-2 -: SEL_W];

    sbc_serial_loader #(.DATA_W(DATA_W)) u_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (upper_wr),
        .data_i       (cpu_data),
        .sel_i        (sel),
        .commit_o     (commit),
        .commit_val_o (commit_val),
        .commit_sel_o (commit_sel),
        .escape_o     (escape)
    );

    sbc_reg_bank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .sel_i    (commit_sel),
        .val_i    (commit_val),
        .escape_i (escape),
        .regs_q_o (regs_q),
        .regs_d_o (regs_nx)
    );

    sbc_bank_map #(.CNT_W(CNT_W)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit),
        .regs_nx_i    (regs_nx),
        .bank_count_i (prg_bank_count),
        .banks_o      (banks)
    );

    assign prg_lo_bank = banks.prg_lo;
    assign prg_hi_bank = banks.prg_hi;
    assign chr_lo_bank = banks.chr_lo;
    assign chr_hi_bank = banks.chr_hi;
    assign mirror_mode = regs_q.ctrl[1:0];

    p_lower_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !cpu_addr[ADDR_W-1]) |=> ($stable(mirror_mode) && $stable(chr_lo_bank)
                                             && $stable(chr_hi_bank)));

    p_mirror_on_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_sel == SEL_CTRL) |=> mirror_mode == $past(commit_val[1:0]));
endmodule

// File: tb/serial_bank_ctrl_test.sv
`timescale 1ns/1ps
module serial_bank_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_we = 1'b0;
    logic [5:0]  prg_bank_count = 6'd16;
    logic [4:0]  prg_lo_bank, prg_hi_bank, chr_lo_bank, chr_hi_bank;
    logic [1:0]  mirror_mode;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model state
    logic [4:0] m_acc;
    int         m_left;
    logic [4:0] m_ctrl, m_chra, m_chrb, m_prg;
    logic [4:0] s_ctrl, s_chra, s_chrb, s_prg;

    always #10 clk = ~clk;

    serial_bank_ctrl uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_addr       (cpu_addr),
        .cpu_data       (cpu_data),
        .cpu_we         (cpu_we),
        .prg_bank_count (prg_bank_count),
        .prg_lo_bank    (prg_lo_bank),
        .prg_hi_bank    (prg_hi_bank),
        .chr_lo_bank    (chr_lo_bank),
        .chr_hi_bank    (chr_hi_bank),
        .mirror_mode    (mirror_mode)
    );

    function automatic logic [4:0] exp_prg_lo();
        case (s_ctrl[3:2])
            2'b10:   return 5'd0;
            2'b11:   return s_prg;
            default: return {s_prg[4:1], 1'b0};
        endcase
    endfunction

    function automatic logic [4:0] exp_prg_hi();
        case (s_ctrl[3:2])
            2'b10:   return s_prg;
            2'b11:   return 5'(prg_bank_count - 6'd1);
            default: return {s_prg[4:1], 1'b1};
        endcase
    endfunction

    function automatic logic [4:0] exp_chr_lo();
        return s_ctrl[4] ? s_chra : {s_chra[4:1], 1'b0};
    endfunction

    function automatic logic [4:0] exp_chr_hi();
        return s_ctrl[4] ? s_chrb : {s_chra[4:1], 1'b1};
    endfunction

    task automatic model_reset();
        m_acc = '0; m_left = 5;
        m_ctrl = 5'h0C; m_chra = '0; m_chrb = '0; m_prg = '0;
        s_ctrl = 5'h0C; s_chra = '0; s_chrb = '0; s_prg = '0;
    endtask

    task automatic model_step(input logic [15:0] a, input logic [7:0] d);
        if (a[15]) begin
            if (d[7]) begin
                m_acc = '0; m_left = 5; m_ctrl[3:2] = 2'b11;
            end else begin
                m_acc = {d[0], m_acc[4:1]};
                if (m_left == 1) begin
                    case (a[14:13])
                        2'd0: m_ctrl = m_acc;
                        2'd1: m_chra = m_acc;
                        2'd2: m_chrb = m_acc;
                        default: m_prg = m_acc;
                    endcase
                    m_left = 5;
                    s_ctrl = m_ctrl; s_chra = m_chra; s_chrb = m_chrb; s_prg = m_prg;
                end else begin
                    m_left = m_left - 1;
                end
            end
        end
    endtask

    task automatic chk(input string req, input string what, input logic [4:0] got, input logic [4:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "prg_lo", prg_lo_bank, exp_prg_lo());
        chk(req, "prg_hi", prg_hi_bank, exp_prg_hi());
        chk(req, "chr_lo", chr_lo_bank, exp_chr_lo());
        chk(req, "chr_hi", chr_hi_bank, exp_chr_hi());
        chk(req, "mirror", {3'b0, mirror_mode}, {3'b0, m_ctrl[1:0]});
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        model_step(a, d);
        check_all(req);
    endtask

    // five serial stores, LSB first; junk in bits 6:1 of data
    task automatic load_value(input logic [1:0] target, input logic [4:0] v, input string req);
        for (int i = 0; i < 5; i++) begin
            logic [15:0] a;
            a = (i == 4) ? {1'b1, target, 13'h0155} : 16'h8000 | 16'($urandom & 16'h7FFF);
            do_write(a, {1'b0, 6'($urandom), v[i]}, req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R5 / R8: serial order, 8 KB character mode, junk data bits ignored
        load_value(2'd1, 5'b10110, "R5");
        chk("R5", "chr_lo value", chr_lo_bank, 5'd22);
        chk("R8", "chr_hi pair", chr_hi_bank, 5'd23);

        // R12: four bits do nothing visible
        for (int i = 0; i < 4; i++) do_write(16'hE000, 8'h01, "R12");
        // R2: lower-half stores, even escape-looking ones, are ignored
        do_write(16'h6000, 8'h80, "R2");
        do_write(16'h7FFF, 8'h01, "R2");
        do_write(16'hE000, 8'h00, "R2");    // fifth upper bit completes prg = 01111 -> 5'b01111
        chk("R2", "prg count kept", prg_lo_bank, 5'd15);

        // R3: escape mid-load restarts
        do_write(16'h8000, 8'h01, "R3");
        do_write(16'h8000, 8'h01, "R3");
        do_write(16'hA000, 8'hFF, "R3");
        load_value(2'd1, 5'b00101, "R3");
        chk("R3", "fresh chr_lo", chr_lo_bank, 5'd4);

        // R7 / R8: control 1_00_11 -> 4 KB chr, prg mode 0, mirror 3
        load_value(2'd0, 5'b10011, "R7");
        chk("R7", "mirror", {3'b0, mirror_mode}, 5'd3);
        load_value(2'd2, 5'b11001, "R8");
        chk("R8", "chr_hi independent", chr_hi_bank, 5'd25);
        chk("R8", "chr_lo independent", chr_lo_bank, 5'd5);

        // R9: pair mode
        load_value(2'd3, 5'b00111, "R9");
        chk("R9", "prg_lo", prg_lo_bank, 5'd6);
        chk("R9", "prg_hi", prg_hi_bank, 5'd7);

        // R10: mode 2
        load_value(2'd0, 5'b01000, "R10");
        chk("R10", "prg_lo", prg_lo_bank, 5'd0);
        chk("R10", "prg_hi", prg_hi_bank, 5'd7);

        // R4 / R12: escape changes nothing visible until the next commit
        do_write(16'hC000, 8'h80, "R4");
        chk("R4", "prg_lo held", prg_lo_bank, 5'd0);
        chk("R4", "mirror kept", {3'b0, mirror_mode}, 5'd0);
        load_value(2'd1, 5'b00010, "R4");
        chk("R4", "prg_lo mode3", prg_lo_bank, 5'd7);
        chk("R4", "prg_hi last", prg_hi_bank, 5'd15);

        // R11: high slot follows the count
        @(negedge clk); prg_bank_count = 6'd8;
        @(negedge clk);
        chk("R11", "prg_hi count 8", prg_hi_bank, 5'd7);
        prg_bank_count = 6'd32;
        @(negedge clk);
        chk("R11", "prg_hi count 32", prg_hi_bank, 5'd31);
        check_all("R11");

        // R6 random mix
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            if (($urandom % 8) != 0) a[15] = 1'b1;
            d = 8'($urandom);
            if (($urandom % 12) != 0) d[7] = 1'b0;
            if (($urandom % 200) == 0) prg_bank_count = 6'(($urandom % 32) + 1);
            do_write(a, d, "R6");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule